// File: doc/BRIEF.md
# Sticky Fault Status with Enable-Pulse Reset Classification

This block gathers single-cycle fault indications from a gate driver's protection circuits. There are five of them: gate-supply undervoltage, gate-supply overvoltage, power-supply undervoltage, overtemperature shutdown and overcurrent shutdown. Each indication is held in a sticky status bit. The status word is presented continuously. A read strobe marks the cycle in which a register read consumes it, and that read clears the bits. Because a fault still present after the read sets its bit again, software reads twice to learn the live condition.

The block also decides how to reset. It counts how long the enable pin stays low in reference-clock cycles and classifies the pulse when enable rises. A long pulse asks the surrounding logic for a full restart and wipes every bit. A short pulse is a quick fault reset that wipes every bit except gate-supply overvoltage. A software gate-reset request behaves like the quick reset. It raises a flag that clears itself once a fixed reset interval has passed. A summary bit is high whenever any latched fault is present, and a separate active-low fault pin carries its inverse.

Top module: `fault_latch_ctl`

## Requirements
- R1: A fault input high for one cycle sets its status bit at the next clock edge. The bit stays set, even with the input low, until a read, an enable-pulse reset or a software reset clears it.
- R2: A clock edge with `rd_stb` high clears every status bit.
- R3: Status word bit positions: bit 0 gate-supply undervoltage, bit 1 gate-supply overvoltage, bit 2 power-supply undervoltage, bit 3 overtemperature shutdown, bit 4 overcurrent shutdown.
- R4: `fault_any` is high exactly when any status bit is set, and `fault_n` is always its inverse.
- R5: When enable rises after having been sampled low on at least `LONG_LOW_CYC` consecutive edges, every status bit clears at that edge, bit 1 included. `restart_req` is high for exactly the following cycle.
- R6: When enable rises after having been sampled low on 1 to `LONG_LOW_CYC`-1 edges, all status bits except bit 1 clear, bit 1 keeps its value, and `restart_req` stays low.
- R7: A `sw_rst_req` edge while `gate_rst` is low clears all bits except bit 1. It also raises `gate_rst`, which stays high for `RST_CYC` cycles and then returns to zero by itself.
- R8: While `gate_rst` is high, `sw_rst_req` is ignored: it neither clears status bits nor extends the flag.
- R9: A fault input high at the same edge as any clear sets its bit regardless of the clear.
- R10: After reset, status is zero, `fault_any`, `restart_req` and `gate_rst` are low, and `fault_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; also times the enable low pulse |
| rst_n | input | 1 | Asynchronous active-low reset |
| gsup_uv | input | 1 | Gate-supply undervoltage event |
| gsup_ov | input | 1 | Gate-supply overvoltage event |
| psup_uv | input | 1 | Power-supply undervoltage event |
| ot_shdn | input | 1 | Overtemperature shutdown event |
| oc_shdn | input | 1 | Overcurrent shutdown event |
| en_pin | input | 1 | Enable pin, already synchronised |
| rd_stb | input | 1 | Status register read strobe |
| sw_rst_req | input | 1 | Software gate-reset write |
| status | output | 5 | Sticky fault bits |
| fault_any | output | 1 | Active-high summary fault |
| fault_n | output | 1 | Active-low fault pin |
| restart_req | output | 1 | One-cycle full-restart request |
| gate_rst | output | 1 | Self-clearing software reset bit |

## Verification
Several behaviours are checked by assertions on every cycle. A fault input always reaches its bit, so fault beats clear. Bits hold when no clear source is active. The summary bit and the pin stay consistent. A restart pulse lasts one cycle and leaves gate-supply overvoltage clear. The reset flag rises only after a request. Only the bench's scenarios can show the classification boundary: enable low durations are swept across the threshold, with the surviving bit computed for each. They also show the exact length of the reset flag, that a request during that flag is ignored, and every one of the 32 fault patterns reaching its documented bit position.

// File: rtl/fault_latch_ctl.sv
module fault_latch_ctl #(
  parameter int LONG_LOW_CYC = 500,
  parameter int RST_CYC      = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       gsup_uv,
  input  logic       gsup_ov,
  input  logic       psup_uv,
  input  logic       ot_shdn,
  input  logic       oc_shdn,
  input  logic       en_pin,
  input  logic       rd_stb,
  input  logic       sw_rst_req,
  output logic [4:0] status,
  output logic       fault_any,
  output logic       fault_n,
  output logic       restart_req,
  output logic       gate_rst
);
  localparam int NF = 5;
  localparam int CW = $clog2(LONG_LOW_CYC + 1);
  localparam int RW = (RST_CYC > 1) ? $clog2(RST_CYC) : 1;
  localparam logic [NF-1:0] OV_KEEP = NF'(2);

  logic [NF-1:0] evt, sts_q, keep;
  logic [CW-1:0] low_cnt;
  logic [RW-1:0] rst_cnt;
  logic          en_d;

  assign evt = {oc_shdn, ot_shdn, psup_uv, gsup_ov, gsup_uv};

  wire en_rise  = en_pin & ~en_d;
  wire long_low = (low_cnt == CW'(LONG_LOW_CYC));
  wire sw_take  = sw_rst_req & ~gate_rst;

  always_comb begin
    keep = '1;
    if (rd_stb)  keep = '0;
    if (en_rise) keep = keep & (long_low ? '0 : OV_KEEP);
    if (sw_take) keep = keep & OV_KEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q       <= '0;
      en_d        <= 1'b1;
      low_cnt     <= '0;
      restart_req <= 1'b0;
    end else begin
      sts_q       <= (sts_q & keep) | evt;
      en_d        <= en_pin;
      restart_req <= en_rise & long_low;
      if (en_pin)         low_cnt <= '0;
      else if (!long_low) low_cnt <= low_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_rst <= 1'b0;
      rst_cnt  <= '0;
    end else if (sw_take) begin
      gate_rst <= 1'b1;
      rst_cnt  <= RW'(RST_CYC - 1);
    end else if (gate_rst) begin
      if (rst_cnt == '0) gate_rst <= 1'b0;
      else               rst_cnt  <= rst_cnt - 1'b1;
    end
  end

  assign status    = sts_q;
  assign fault_any = |sts_q;
  assign fault_n   = ~fault_any;
endmodule

// File: rtl/fault_latch_ctl_chk.sv
module fault_latch_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [4:0] evt,
  input logic       en_pin,
  input logic       rd_stb,
  input logic       sw_rst_req,
  input logic [4:0] status,
  input logic       fault_any,
  input logic       fault_n,
  input logic       restart_req,
  input logic       gate_rst
);
  assert_fault_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((status & $past(evt)) == $past(evt)));

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stb && en_pin && $past(en_pin) && !sw_rst_req) |=>
      ((status & $past(status)) == $past(status)));

  assert_summary_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_any == (|status)) && (fault_n == !fault_any));

  assert_restart_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
    restart_req |=> !restart_req);

  assert_restart_ov_R5: assert property (@(posedge clk) disable iff (!rst_n)
    restart_req |-> (status[1] == $past(evt[1])));

  assert_flag_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_rst) |-> $past(sw_rst_req));

  always_comb
    if (!rst_n) assert_reset_R10: assert (status == '0 && !restart_req && !gate_rst);
endmodule

bind fault_latch_ctl fault_latch_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .evt(evt), .en_pin(en_pin), .rd_stb(rd_stb),
  .sw_rst_req(sw_rst_req), .status(status), .fault_any(fault_any),
  .fault_n(fault_n), .restart_req(restart_req), .gate_rst(gate_rst)
);

// File: tb/sim_fault_latch_ctl.sv
module sim_fault_latch_ctl;
  localparam int LONG = 8;
  localparam int RCYC = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0] ev = '0;
  logic en_pin = 1'b1, rd_stb = 1'b0, sw_rst_req = 1'b0;
  logic [4:0] status;
  logic fault_any, fault_n, restart_req, gate_rst;
  int checks = 0, errors = 0, cyc = 0;

  always #10 clk = ~clk;

  fault_latch_ctl #(.LONG_LOW_CYC(LONG), .RST_CYC(RCYC)) u0 (
    .clk(clk), .rst_n(rst_n), .gsup_uv(ev[0]), .gsup_ov(ev[1]), .psup_uv(ev[2]),
    .ot_shdn(ev[3]), .oc_shdn(ev[4]), .en_pin(en_pin), .rd_stb(rd_stb),
    .sw_rst_req(sw_rst_req), .status(status), .fault_any(fault_any),
    .fault_n(fault_n), .restart_req(restart_req), .gate_rst(gate_rst));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic pulse_ev(input logic [4:0] v);
    ev = v; tick(); ev = '0;
  endtask

  task automatic clear_all();
    rd_stb = 1'b1; tick(); rd_stb = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    chk("R10 status", status, 0);
    chk("R10 fault_n", fault_n, 1);
    chk("R10 flags", {fault_any, restart_req, gate_rst}, 0);
    rst_n = 1'b1; tick();

    for (int p = 0; p < 32; p++) begin
      pulse_ev(5'(p));
      chk("R3 position", status, p);
      chk("R4 summary", {fault_any, fault_n}, {p != 0, p == 0});
      tick(); tick();
      chk("R1 sticky", status, p);
      clear_all();
      chk("R2 read clear", status, 0);
    end

    for (int q = 0; q < 32; q += 5) begin
      pulse_ev(5'h1f);
      rd_stb = 1'b1; ev = 5'(q); tick(); rd_stb = 1'b0; ev = '0;
      chk("R9 read vs fault", status, q);
      clear_all();
    end

    for (int d = 1; d <= LONG + 3; d++) begin
      pulse_ev(5'h1f);
      en_pin = 1'b0;
      for (int k = 0; k < d; k++) tick();
      chk("R6 hold during low", status, 5'h1f);
      en_pin = 1'b1; tick();
      chk(d >= LONG ? "R5 long clear" : "R6 quick clear", status, d >= LONG ? 0 : 2);
      chk(d >= LONG ? "R5 restart" : "R6 no restart", restart_req, d >= LONG);
      tick();
      chk("R5 restart one cycle", restart_req, 0);
      clear_all();
    end

    pulse_ev(5'h1f);
    en_pin = 1'b0; tick(); tick();
    en_pin = 1'b1; ev = 5'h1f; tick(); ev = '0;
    chk("R9 quick vs fault", status, 5'h1f);
    clear_all();

    pulse_ev(5'h1f);
    sw_rst_req = 1'b1; tick(); sw_rst_req = 1'b0;
    chk("R7 sw clear", status, 2);
    begin
      int hi = 1;
      pulse_ev(5'h1f);
      hi++;
      sw_rst_req = 1'b1; tick(); sw_rst_req = 1'b0;
      hi++;
      chk("R8 ignored while busy", status, 5'h1f);
      while (gate_rst && hi < 50) begin tick(); hi++; end
      chk("R7 flag length", hi - 1, RCYC);
      chk("R8 no extension", gate_rst, 0);
    end
    sw_rst_req = 1'b1; ev = 5'h01; tick(); sw_rst_req = 1'b0; ev = '0;
    chk("R9 sw vs fault", status, 5'h03);
    chk("R7 flag set", gate_rst, 1);
    for (int k = 0; k < RCYC; k++) tick();
    chk("R7 self clear", gate_rst, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule